// File: doc/BRIEF.md
# Flash Command Front End with Identification and Protection Register

This block is the command decoder of a 16-bit-wide flash device. Command bytes arrive on a synchronous write strobe. They move the device between three read views: the array, the identification space and the status register. They also drive block locking, loading of the read configuration register, programming of a one-time protection register and a block erase that can be suspended and resumed. The flash array itself is abstracted: array reads return the erased pattern FFFFh, and an erase is a fixed countdown of `ERASE_CYC` cycles.

The identification space returns the manufacturer and device codes, the lock state of the addressed block and the read configuration register. It also returns a 128-bit protection register. The lower half is a factory number fixed by parameter. The upper half starts blank and can be programmed until a lock bit freezes it. Two sticky error bits in the status register report bad command sequences. Once set they survive a suspend and resume of an erase, so a failure of the resumed erase cannot be told apart from the earlier error. Only the clear command resets them.

Addresses are `ADDR_W` bits wide. The top `BLK_W` bits select a block, the top `BANK_W` bits select a bank, and the remaining low bits form the identification offset.

Top module: `fcmd_frontend`

## Requirements
- R1: After reset the block is in array mode, `rdata` is 0000h, the status byte is 80h, every block reads as locked (0001h), the user protection words read FFFFh and the protection lock word reads 0001h.
- R2: Command 90h written to an address in bank 0 selects the identification view. Written to any other bank it has no effect. Command FFh selects array mode, where every read returns FFFFh.
- R3: In the identification view, offset 0 reads 002Ch. Offset 1 reads 44B6h when `boot_top` is 1 and 44B7h when it is 0.
- R4: In the identification view, offset 2 reads the lock state of the block selected by the top address bits: 0000h open, 0001h locked, 0003h locked down.
- R5: The setup byte 60h followed by a confirm byte acts on the block of the confirm address, and leaves the status view selected. The confirm 01h locks the block, D0h opens it and 2Fh locks it down. A locked-down block ignores both open and lock. The confirm 03h loads the read configuration register (reset value B5CFh, readable at offset 5) with the low 16 address bits.
- R6: After 60h, any other confirm byte sets status bits 5 and 4 (status B0h) and changes no lock state.
- R7: Command 50h clears status bits 5 and 4. FFh, 90h, 70h and resume leave them set.
- R8: Offset 80h reads the protection lock word {user-lock in bit 1, 1 in bit 0}. Offsets 81h to 84h read the factory number, least significant word first. Offsets 85h to 88h read the user words. Every other offset reads 0000h.
- R9: Byte C0h followed by a write to offset 85h to 88h ANDs the data into that user word. A write to 80h with data bit 1 set sets the user lock.
- R10: A protection program to 81h to 84h, to a locked user word, or to an offset outside 80h to 88h sets status bit 4 (status 90h) and changes no stored word.
- R11: Byte 20h then D0h on an open block makes the status 00h and forces status reads until `ERASE_CYC` cycles have passed, after which the status is 80h. D0h on a block that is not open sets bit 5 (status A0h) and starts nothing. Any byte other than D0h after 20h sets bits 5 and 4.
- R12: B0h during a running erase suspends it: status C0h, countdown held, other commands usable. D0h resumes the countdown.
- R13: When the erase block has become locked by completion, bit 5 is set. Bits set by a lock-sequence error during a suspend persist through resume and completion, so status reads B0h whether or not the resumed erase failed.
- R14: Command 70h selects the status view. There reads return {00h, status byte}, and bit 7 is 1 whenever no erase is counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Command or data write strobe |
| rd_en | input | 1 | Read strobe; `rdata` updates at the same edge |
| addr | input | ADDR_W | Block, bank and offset address |
| wdata | input | 16 | Write data; low byte is the command code |
| boot_top | input | 1 | 1 selects the top-boot device code |
| rdata | output | 16 | Registered read data |

## Verification
A wrong read mode or command state shows up on the first read after the faulty write. That read returns the wrong view, such as FFFFh instead of an identification word. A lost or stuck sticky bit appears in the next status read, typically one write after the error sequence. A miscounted or unheld erase countdown shows as a status read that reports busy or ready at the wrong cycle, within `ERASE_CYC` cycles of the confirm or resume. A lock or protection word that changes when it should not is visible on the next identification read of that offset.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_ID     = 2'd1,
    MODE_STATUS = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_LOCK  = 2'd1,
    CS_ERASE = 2'd2,
    CS_PROT  = 2'd3
  } cmd_state_e;

  localparam logic [1:0] LK_OPEN   = 2'b00;
  localparam logic [1:0] LK_SHUT   = 2'b01;
  localparam logic [1:0] LK_FROZEN = 2'b11;

  localparam logic [7:0] OP_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] OP_READ_ID      = 8'h90;
  localparam logic [7:0] OP_READ_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] OP_LOCK_SETUP   = 8'h60;
  localparam logic [7:0] OP_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] OP_PROT_PROG    = 8'hC0;
  localparam logic [7:0] OP_SUSPEND      = 8'hB0;
  localparam logic [7:0] OP_CONFIRM      = 8'hD0;
  localparam logic [7:0] OP_LOCK_SET     = 8'h01;
  localparam logic [7:0] OP_LOCK_DOWN    = 8'h2F;
  localparam logic [7:0] OP_RCR_LOAD     = 8'h03;

  localparam logic [15:0] MFR_CODE   = 16'h002C;
  localparam logic [15:0] DEV_TOP    = 16'h44B6;
  localparam logic [15:0] DEV_BOTTOM = 16'h44B7;
endpackage

// File: rtl/fcmd_lock_table.sv
module fcmd_lock_table
  import fcmd_pkg::*;
#(
  parameter int BLK_W = 3,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       upd_en,
  input  logic [BLK_W-1:0]           upd_blk,
  input  logic [1:0]                 upd_state,
  output logic [NUM_BLK-1:0][1:0]    states
);
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic [1:0] st_q, st_d;

    always_comb begin
      st_d = st_q;
      if (upd_en && (upd_blk == BLK_W'(g)) && (st_q != LK_FROZEN)) begin
        st_d = upd_state;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= LK_SHUT;
      else        st_q <= st_d;
    end

    assign states[g] = st_q;

    // R5: a locked-down block never leaves that state
    assert_lockdown_sticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == LK_FROZEN) |=> (st_q == LK_FROZEN))
      else $error("lock-down state left");
  end
endmodule

// File: rtl/fcmd_prot_reg.sv
module fcmd_prot_reg #(
  parameter logic [63:0] FACTORY_ID = 64'h1357_9BDF_2468_ACE0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prog_en,
  input  logic [3:0]  prog_idx,
  input  logic [15:0] prog_data,
  input  logic [3:0]  rd_idx,
  output logic [15:0] rd_word,
  output logic        user_lock
);
  localparam int USER_WORDS = 4;
  localparam int USER_BASE  = 5;

  logic                             lock_q, lock_d;
  logic [USER_WORDS-1:0][15:0]      user_q, user_d;

  always_comb begin
    lock_d = lock_q;
    if (prog_en && (prog_idx == 4'd0) && prog_data[1]) lock_d = 1'b1;
  end

  for (genvar g = 0; g < USER_WORDS; g++) begin : g_user
    always_comb begin
      user_d[g] = user_q[g];
      if (prog_en && (prog_idx == 4'(USER_BASE + g))) user_d[g] = user_q[g] & prog_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      user_q <= '1;
    end else begin
      lock_q <= lock_d;
      user_q <= user_d;
    end
  end

  always_comb begin
    rd_word = 16'h0000;
    if (rd_idx == 4'd0) begin
      rd_word = {14'd0, lock_q, 1'b1};
    end else if (rd_idx <= 4'd4) begin
      rd_word = FACTORY_ID[16*(int'(rd_idx)-1) +: 16];
    end else if (rd_idx <= 4'd8) begin
      rd_word = user_q[int'(rd_idx)-USER_BASE];
    end
  end

  assign user_lock = lock_q;

  // R9: programming only clears user bits
  assert_user_bits_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((user_q & ~$past(user_q)) == '0))
    else $error("user bit went from 0 to 1");

  // R10: locked user segment is frozen
  assert_user_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(user_q))
    else $error("locked user word changed");
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          BLK_W     = 3,
  parameter int          BANK_W    = 1,
  parameter int          ERASE_CYC = 16,
  parameter logic [15:0] RCR_RESET = 16'hB5CF,
  localparam int         OFS_W     = ADDR_W - BLK_W,
  localparam int         CNT_W     = $clog2(ERASE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        cmd,
  input  logic [1:0]        addr_blk_lock,
  input  logic [1:0]        erase_blk_lock,
  input  logic              user_lock,
  output rd_mode_e          mode,
  output logic              lock_upd,
  output logic [BLK_W-1:0]  lock_blk,
  output logic [1:0]        lock_state,
  output logic              prot_upd,
  output logic [3:0]        prot_idx,
  output logic [15:0]       rcr,
  output logic [7:0]        status,
  output logic [BLK_W-1:0]  erase_blk
);
  rd_mode_e          mode_q, mode_d;
  cmd_state_e        cs_q, cs_d;
  logic              err4_q, err4_d, err5_q, err5_d;
  logic              act_q, act_d, susp_q, susp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BLK_W-1:0]  eblk_q, eblk_d;
  logic [15:0]       rcr_q, rcr_d;

  logic [OFS_W-1:0]  ofs;
  logic              in_bank0;
  logic              prot_range;
  logic              running;

  assign ofs        = addr[OFS_W-1:0];
  assign in_bank0   = (addr[ADDR_W-1 -: BANK_W] == '0);
  assign prot_range = (ofs >= OFS_W'('h80)) && (ofs <= OFS_W'('h88));
  assign running    = act_q && !susp_q;
  assign lock_blk   = addr[ADDR_W-1 -: BLK_W];
  assign prot_idx   = ofs[3:0];

  always_comb begin
    mode_d     = mode_q;
    cs_d       = cs_q;
    err4_d     = err4_q;
    err5_d     = err5_q;
    act_d      = act_q;
    susp_d     = susp_q;
    cnt_d      = cnt_q;
    eblk_d     = eblk_q;
    rcr_d      = rcr_q;
    lock_upd   = 1'b0;
    lock_state = LK_SHUT;
    prot_upd   = 1'b0;

    if (running) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
        if (erase_blk_lock != LK_OPEN) err5_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    if (wr_en) begin
      if (running) begin
        if (cmd == OP_SUSPEND && cnt_q != '0) begin
          susp_d = 1'b1;
          mode_d = MODE_STATUS;
        end else if (cmd == OP_READ_STATUS) begin
          mode_d = MODE_STATUS;
        end
      end else begin
        unique case (cs_q)
          CS_LOCK: begin
            cs_d   = CS_IDLE;
            mode_d = MODE_STATUS;
            case (cmd)
              OP_LOCK_SET:  begin lock_upd = 1'b1; lock_state = LK_SHUT;   end
              OP_CONFIRM:   begin lock_upd = 1'b1; lock_state = LK_OPEN;   end
              OP_LOCK_DOWN: begin lock_upd = 1'b1; lock_state = LK_FROZEN; end
              OP_RCR_LOAD:  rcr_d = 16'(addr);
              default: begin err4_d = 1'b1; err5_d = 1'b1; end
            endcase
          end
          CS_ERASE: begin
            cs_d   = CS_IDLE;
            mode_d = MODE_STATUS;
            if (cmd == OP_CONFIRM) begin
              if (addr_blk_lock != LK_OPEN) begin
                err5_d = 1'b1;
              end else begin
                act_d  = 1'b1;
                cnt_d  = CNT_W'(ERASE_CYC - 1);
                eblk_d = lock_blk;
              end
            end else begin
              err4_d = 1'b1;
              err5_d = 1'b1;
            end
          end
          CS_PROT: begin
            cs_d   = CS_IDLE;
            mode_d = MODE_STATUS;
            if (prot_range && (prot_idx == 4'd0 || (prot_idx >= 4'd5 && !user_lock))) begin
              prot_upd = 1'b1;
            end else begin
              err4_d = 1'b1;
            end
          end
          default: begin
            case (cmd)
              OP_READ_ARRAY:   mode_d = MODE_ARRAY;
              OP_READ_ID:      if (in_bank0) mode_d = MODE_ID;
              OP_READ_STATUS:  mode_d = MODE_STATUS;
              OP_CLEAR_STATUS: begin err4_d = 1'b0; err5_d = 1'b0; end
              OP_LOCK_SETUP:   cs_d = CS_LOCK;
              OP_ERASE_SETUP:  if (!act_q) cs_d = CS_ERASE;
              OP_PROT_PROG:    cs_d = CS_PROT;
              OP_CONFIRM: begin
                if (susp_q) begin
                  susp_d = 1'b0;
                  mode_d = MODE_STATUS;
                end
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      cs_q   <= CS_IDLE;
      err4_q <= 1'b0;
      err5_q <= 1'b0;
      act_q  <= 1'b0;
      susp_q <= 1'b0;
      cnt_q  <= '0;
      eblk_q <= '0;
      rcr_q  <= RCR_RESET;
    end else begin
      mode_q <= mode_d;
      cs_q   <= cs_d;
      err4_q <= err4_d;
      err5_q <= err5_d;
      act_q  <= act_d;
      susp_q <= susp_d;
      cnt_q  <= cnt_d;
      eblk_q <= eblk_d;
      rcr_q  <= rcr_d;
    end
  end

  assign mode      = mode_q;
  assign rcr       = rcr_q;
  assign erase_blk = eblk_q;
  assign status    = {~running, susp_q, err5_q, err4_q, 4'b0000};

  // R7: error bits only fall after a clear byte
  assert_err4_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err4_q && !(wr_en && cmd == OP_CLEAR_STATUS)) |=> err4_q)
    else $error("bit 4 cleared without clear command");

  assert_err5_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err5_q && !(wr_en && cmd == OP_CLEAR_STATUS)) |=> err5_q)
    else $error("bit 5 cleared without clear command");

  // R12: suspended erase keeps its count
  assert_suspend_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |=> (act_q && cnt_q == $past(cnt_q)))
    else $error("count moved while suspended");

  // R11: erase only starts on an open block after a confirm write
  assert_erase_open_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> ($past(addr_blk_lock) == LK_OPEN && $past(wr_en) && $past(cmd) == OP_CONFIRM))
    else $error("erase started illegally");
endmodule

// File: rtl/fcmd_read_mux.sv
module fcmd_read_mux
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3,
  localparam int OFS_W   = ADDR_W - BLK_W,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  rd_mode_e                  mode,
  input  logic [7:0]                status,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      boot_top,
  input  logic [NUM_BLK-1:0][1:0]   lock_states,
  input  logic [15:0]               rcr,
  input  logic [15:0]               prot_word,
  output logic [15:0]               rd_word
);
  logic [OFS_W-1:0] ofs;
  logic [BLK_W-1:0] blk;
  logic [15:0]      id_word;

  assign ofs = addr[OFS_W-1:0];
  assign blk = addr[ADDR_W-1 -: BLK_W];

  always_comb begin
    id_word = 16'h0000;
    if (ofs == OFS_W'(0))      id_word = MFR_CODE;
    else if (ofs == OFS_W'(1)) id_word = boot_top ? DEV_TOP : DEV_BOTTOM;
    else if (ofs == OFS_W'(2)) id_word = {14'd0, lock_states[blk]};
    else if (ofs == OFS_W'(5)) id_word = rcr;
    else if (ofs >= OFS_W'('h80) && ofs <= OFS_W'('h88)) id_word = prot_word;
  end

  always_comb begin
    if (!status[7]) begin
      rd_word = {8'h00, status};
    end else begin
      unique case (mode)
        MODE_ID:     rd_word = id_word;
        MODE_STATUS: rd_word = {8'h00, status};
        default:     rd_word = 16'hFFFF;
      endcase
    end
  end
endmodule

// File: rtl/fcmd_frontend.sv
module fcmd_frontend
  import fcmd_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          BLK_W      = 3,
  parameter int          BANK_W     = 1,
  parameter int          ERASE_CYC  = 16,
  parameter logic [15:0] RCR_RESET  = 16'hB5CF,
  parameter logic [63:0] FACTORY_ID = 64'h1357_9BDF_2468_ACE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              boot_top,
  output logic [15:0]       rdata
);
  localparam int NUM_BLK = 1 << BLK_W;

  logic [1:0]                rst_sync;
  logic                      rst_int_n;
  rd_mode_e                  mode;
  logic                      lock_upd, prot_upd, user_lock;
  logic [BLK_W-1:0]          lock_blk, erase_blk, addr_blk;
  logic [1:0]                lock_state;
  logic [3:0]                prot_idx;
  logic [15:0]               rcr, prot_word, rd_word;
  logic [7:0]                status;
  logic [NUM_BLK-1:0][1:0]   lock_states;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign addr_blk = addr[ADDR_W-1 -: BLK_W];

  fcmd_decoder #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .BANK_W(BANK_W),
    .ERASE_CYC(ERASE_CYC), .RCR_RESET(RCR_RESET)
  ) u_dec (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .cmd(wdata[7:0]),
    .addr_blk_lock(lock_states[addr_blk]), .erase_blk_lock(lock_states[erase_blk]),
    .user_lock(user_lock), .mode(mode), .lock_upd(lock_upd), .lock_blk(lock_blk),
    .lock_state(lock_state), .prot_upd(prot_upd), .prot_idx(prot_idx), .rcr(rcr),
    .status(status), .erase_blk(erase_blk)
  );

  fcmd_lock_table #(.BLK_W(BLK_W)) u_locks (
    .clk(clk), .rst_n(rst_int_n), .upd_en(lock_upd), .upd_blk(lock_blk),
    .upd_state(lock_state), .states(lock_states)
  );

  fcmd_prot_reg #(.FACTORY_ID(FACTORY_ID)) u_prot (
    .clk(clk), .rst_n(rst_int_n), .prog_en(prot_upd), .prog_idx(prot_idx),
    .prog_data(wdata), .rd_idx(addr[3:0]), .rd_word(prot_word), .user_lock(user_lock)
  );

  fcmd_read_mux #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_mux (
    .mode(mode), .status(status), .addr(addr), .boot_top(boot_top),
    .lock_states(lock_states), .rcr(rcr), .prot_word(prot_word), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata <= 16'h0000;
    else if (rd_en)  rdata <= rd_word;
  end
endmodule

// File: tb/fcmd_frontend_bench.sv
module fcmd_frontend_bench;
  localparam int ERASE_CYC = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, boot_top;
  logic [15:0] addr, wdata;
  logic [15:0] rdata;

  int n_checks = 0;
  int n_fails  = 0;
  logic rd_q = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  fcmd_frontend #(.ERASE_CYC(ERASE_CYC)) u_fcmd_frontend (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .boot_top(boot_top), .rdata(rdata)
  );

  always @(posedge clk) rd_q <= rd_en;

  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL unexpected read data: actual %h expected none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (rdata !== e) begin
          n_fails++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic put_cmd(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; boot_top = 1'b1;
    repeat (3) @(negedge clk);
    n_checks++;
    if (rdata !== 16'h0000) begin
      n_fails++;
      $display("FAIL R1 reset rdata: actual %h expected 0000", rdata);
    end
    rst_n = 1'b1;
    idle(4);

    // R1 / R2: array mode after reset
    expect_rd(16'h0000, 16'hFFFF, "R1 array after reset");
    put_cmd(16'h0000, 16'h0070);
    expect_rd(16'h0000, 16'h0080, "R1 reset status");
    put_cmd(16'h0000, 16'h00FF);
    put_cmd(16'h8000, 16'h0090);
    expect_rd(16'h0000, 16'hFFFF, "R2 id in other bank ignored");
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0000, 16'h002C, "R3 manufacturer");
    expect_rd(16'h0001, 16'h44B6, "R3 top boot");
    boot_top = 1'b0;
    expect_rd(16'h0001, 16'h44B7, "R3 bottom boot");
    expect_rd(16'h4002, 16'h0001, "R1 R4 reset lock");
    expect_rd(16'h0005, 16'hB5CF, "R5 rcr reset");
    expect_rd(16'h0080, 16'h0001, "R1 R8 lock word");
    expect_rd(16'h0081, 16'hACE0, "R8 factory low");
    expect_rd(16'h0084, 16'h1357, "R8 factory high");
    expect_rd(16'h0085, 16'hFFFF, "R1 user blank");
    expect_rd(16'h0089, 16'h0000, "R8 beyond range");
    expect_rd(16'h0003, 16'h0000, "R8 reserved offset");
    put_cmd(16'h0000, 16'h00FF);
    expect_rd(16'h0000, 16'hFFFF, "R2 back to array");

    // R5: lock commands
    put_cmd(16'h4000, 16'h0060); put_cmd(16'h4000, 16'h00D0);
    expect_rd(16'h0000, 16'h0080, "R5 status after confirm");
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h4002, 16'h0000, "R4 R5 block open");
    put_cmd(16'h6000, 16'h0060); put_cmd(16'h6000, 16'h002F);
    put_cmd(16'h6000, 16'h0060); put_cmd(16'h6000, 16'h00D0);
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h6002, 16'h0003, "R4 R5 lockdown holds");
    put_cmd(16'h0000, 16'h0060); put_cmd(16'h1234, 16'h0003);
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0005, 16'h1234, "R5 rcr load");
    put_cmd(16'h0000, 16'h0070);
    expect_rd(16'h0000, 16'h0080, "R14 status view");

    // R6 / R7: lock sequence error
    put_cmd(16'h2000, 16'h0060); put_cmd(16'h2000, 16'h00FF);
    expect_rd(16'h0000, 16'h00B0, "R6 bad confirm");
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h2002, 16'h0001, "R6 lock unchanged");
    put_cmd(16'h0000, 16'h00FF);
    put_cmd(16'h0000, 16'h0070);
    expect_rd(16'h0000, 16'h00B0, "R7 survives FF 90 70");
    put_cmd(16'h0000, 16'h0050);
    expect_rd(16'h0000, 16'h0080, "R7 clear");

    // R9 / R10: protection register
    put_cmd(16'h0000, 16'h00C0); put_cmd(16'h0085, 16'h0F0F);
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0085, 16'h0F0F, "R9 user program");
    put_cmd(16'h0000, 16'h00C0); put_cmd(16'h0085, 16'hFF00);
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0085, 16'h0F00, "R9 program ANDs");
    put_cmd(16'h0000, 16'h0070);
    expect_rd(16'h0000, 16'h0080, "R9 no error");
    put_cmd(16'h0000, 16'h00C0); put_cmd(16'h0081, 16'h0000);
    expect_rd(16'h0000, 16'h0090, "R10 factory rejected");
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0081, 16'hACE0, "R10 factory unchanged");
    put_cmd(16'h0000, 16'h0050);
    put_cmd(16'h0000, 16'h00C0); put_cmd(16'h0099, 16'h0000);
    expect_rd(16'h0000, 16'h0090, "R10 out of range rejected");
    put_cmd(16'h0000, 16'h0050);
    put_cmd(16'h0000, 16'h00C0); put_cmd(16'h0080, 16'h0002);
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0080, 16'h0003, "R9 user lock set");
    put_cmd(16'h0000, 16'h00C0); put_cmd(16'h0086, 16'h0000);
    expect_rd(16'h0000, 16'h0090, "R10 locked user rejected");
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0086, 16'hFFFF, "R10 locked user unchanged");
    put_cmd(16'h0000, 16'h0050);

    // R11: erase
    put_cmd(16'h4000, 16'h0020); put_cmd(16'h4000, 16'h00D0);
    expect_rd(16'h0000, 16'h0000, "R11 busy");
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0000, 16'h0000, "R11 busy forces status");
    idle(ERASE_CYC + 2);
    expect_rd(16'h0000, 16'h0080, "R11 erase done");
    put_cmd(16'h2000, 16'h0020); put_cmd(16'h2000, 16'h00D0);
    expect_rd(16'h0000, 16'h00A0, "R11 locked block");
    put_cmd(16'h0000, 16'h0050);
    put_cmd(16'h4000, 16'h0020); put_cmd(16'h4000, 16'h00FF);
    expect_rd(16'h0000, 16'h00B0, "R11 bad erase confirm");
    put_cmd(16'h0000, 16'h0050);

    // R12 / R13: suspend with nested lock error
    put_cmd(16'h4000, 16'h0020); put_cmd(16'h4000, 16'h00D0);
    put_cmd(16'h0000, 16'h00B0);
    expect_rd(16'h0000, 16'h00C0, "R12 suspended");
    idle(ERASE_CYC + 2);
    expect_rd(16'h0000, 16'h00C0, "R12 count held");
    put_cmd(16'h0000, 16'h0090);
    expect_rd(16'h0000, 16'h002C, "R12 id while suspended");
    put_cmd(16'h0000, 16'h0060); put_cmd(16'h0000, 16'h00FF);
    expect_rd(16'h0000, 16'h00F0, "R13 error during suspend");
    put_cmd(16'h0000, 16'h00D0);
    expect_rd(16'h0000, 16'h0030, "R12 R13 resumed busy");
    idle(ERASE_CYC + 2);
    expect_rd(16'h0000, 16'h00B0, "R13 persist after completion");
    put_cmd(16'h0000, 16'h0050);

    // R13: erase failure visible alone
    put_cmd(16'h4000, 16'h0020); put_cmd(16'h4000, 16'h00D0);
    put_cmd(16'h0000, 16'h00B0);
    put_cmd(16'h4000, 16'h0060); put_cmd(16'h4000, 16'h0001);
    put_cmd(16'h0000, 16'h00D0);
    idle(ERASE_CYC + 2);
    expect_rd(16'h0000, 16'h00A0, "R13 erase failure visible");
    put_cmd(16'h0000, 16'h0050);
    put_cmd(16'h4000, 16'h0060); put_cmd(16'h4000, 16'h00D0);

    // R13: erase failure hidden behind lock error
    put_cmd(16'h4000, 16'h0020); put_cmd(16'h4000, 16'h00D0);
    put_cmd(16'h0000, 16'h00B0);
    put_cmd(16'h4000, 16'h0060); put_cmd(16'h4000, 16'h0001);
    put_cmd(16'h0000, 16'h0060); put_cmd(16'h0000, 16'h00AA);
    put_cmd(16'h0000, 16'h00D0);
    idle(ERASE_CYC + 2);
    expect_rd(16'h0000, 16'h00B0, "R13 erase failure hidden");

    idle(4);
    if (exp_q.size() != 0) begin
      n_checks++; n_fails++;
      $display("FAIL scoreboard drain: actual %0d left expected 0", exp_q.size());
    end
    summary();
  end
endmodule